// File: doc/BRIEF.md
# HDLC Interrupt Mask and Status Pair

This block is the interrupt register pair of an HDLC controller. Eight event sources report single-cycle pulses. Each pulse sets a sticky bit in an 8-bit status register, whatever the mask holds. The sources are a D-channel collision, receive end-of-packet, transmit end-of-packet, frame abort, transmit FIFO low, transmit underrun, receive FIFO full and receive overflow. An 8-bit mask register can only be written, and the status register can only be read. Both sit at one address, so a write strobe loads the mask and a read strobe returns the status. A read clears every latched bit.

One registered interrupt line goes high when any latched bit is also enabled in the mask. The collision source is built in. It compares the received echo bit with the D bit just sent, on a strobe, and counts only in terminal mode with the transmitter enabled. In network mode the collision bit is held at zero.

Top module: `hdlc_irq_regs`

## Requirements
- R1: `ev_pulse` bit 6 is receive end-of-packet, bit 5 transmit end-of-packet, bit 4 frame abort, bit 3 transmit FIFO low, bit 2 transmit underrun, bit 1 receive FIFO full and bit 0 receive overflow. A pulse on bit i sets status bit i at the next clock edge whatever the mask holds, and the bit stays set until a clearing read.
- R2: A clock edge with `cpu_sel` and `cpu_wr` both high loads `cpu_wdata` into the mask. Mask bit i set to 1 enables status bit i onto the interrupt line; 0 blocks it.
- R3: A clock edge with `cpu_sel` and `cpu_rd` both high clears every status bit. `cpu_rdata` shows the status throughout that cycle.
- R4: An event that arrives at the same edge as a clearing read leaves its bit set after the read.
- R5: Status bit 7, the collision bit, is set at an edge where `col_strobe` is high, `rx_echo` differs from `tx_dbit`, `mode_te` is 1 and `tx_en` is 1. Under any other condition it does not set.
- R6: While `mode_te` is 0, status bit 7 reads as 0 and adds nothing to the interrupt. A bit 7 latched earlier in terminal mode is cleared at the next edge.
- R7: `irq` is registered. After each edge it equals the OR over all bits of the visible status AND the mask, both taken from before that edge.
- R8: After reset the status, the mask, `irq` and `cpu_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Address select for the register pair |
| cpu_rd | input | 1 | Read strobe; with `cpu_sel` it clears the status |
| cpu_wr | input | 1 | Write strobe; with `cpu_sel` it loads the mask |
| cpu_wdata | input | 8 | Mask write data |
| cpu_rdata | output | 8 | Visible status |
| ev_pulse | input | 7 | Event pulses for status bits 6..0 |
| mode_te | input | 1 | 1 = terminal mode, 0 = network mode |
| tx_en | input | 1 | HDLC transmitter enabled |
| col_strobe | input | 1 | Echo comparison strobe |
| rx_echo | input | 1 | Received echo bit |
| tx_dbit | input | 1 | D bit just transmitted |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle the assertions check the following:
- the mask load;
- that a clearing read leaves only the bits of events arriving in the same cycle;
- that bits never fall without a read;
- that a collision bit only rises under the terminal-mode and transmitter-enabled condition;
- that `irq` follows the masked status one cycle later.

Some behaviour only the bench scenarios can show. One case is a collision latched in terminal mode that is hidden and then dropped after a switch to network mode. Another is a matching echo, or a disabled transmitter, that raises nothing. The third is the effect of each mask bit, which shows only through `irq` because the mask cannot be read back.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
  localparam int IRQ_W    = 8;
  localparam int COLL_IDX = IRQ_W - 1;

  // Status as software sees it: the collision bit is hidden outside terminal mode.
  function automatic logic [IRQ_W-1:0] visible_status(input logic [IRQ_W-1:0] st,
                                                      input logic te);
    logic [IRQ_W-1:0] v;
    v = st;
    v[COLL_IDX] = st[COLL_IDX] & te;
    return v;
  endfunction

  function automatic logic any_enabled(input logic [IRQ_W-1:0] st,
                                       input logic [IRQ_W-1:0] mk);
    return |(st & mk);
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wdata;
  end

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mask_q == $past(wdata));
endmodule

// File: rtl/irq_coll_detect.sv
module irq_coll_detect (
  input  logic strobe,
  input  logic echo,
  input  logic dbit,
  input  logic mode_te,
  input  logic tx_en,
  output logic hit
);
  logic mismatch;
  assign mismatch = echo ^ dbit;
  assign hit      = strobe & mismatch & mode_te & tx_en;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] ev,
  input  logic         drop_top,
  output logic [W-1:0] status_q
);
  logic [W-1:0] kept, nxt;

  assign kept = clr ? '0 : status_q;

  always_comb begin
    nxt = kept | ev;
    if (drop_top) nxt[W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= nxt;
  end

  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status_q[W-2:0] & $past(status_q[W-2:0])) == $past(status_q[W-2:0])));

  assert_event_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev[W-2:0]) |=> ((status_q[W-2:0] & $past(ev[W-2:0])) == $past(ev[W-2:0])));

  assert_clear_keeps_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !drop_top) |=> status_q == $past(ev));

  assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev == '0) |=> status_q == '0);
endmodule

// File: rtl/hdlc_irq_regs.sv
module hdlc_irq_regs
  import hdlc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_sel,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [IRQ_W-1:0] cpu_wdata,
  output logic [IRQ_W-1:0] cpu_rdata,
  input  logic [IRQ_W-2:0] ev_pulse,
  input  logic             mode_te,
  input  logic             tx_en,
  input  logic             col_strobe,
  input  logic             rx_echo,
  input  logic             tx_dbit,
  output logic             irq
);
  logic             mask_wr, rd_clr, coll_hit, irq_d;
  logic [IRQ_W-1:0] mask_q, status_q, ev_all, vis;

  assign mask_wr = cpu_sel & cpu_wr;
  assign rd_clr  = cpu_sel & cpu_rd;

  irq_mask_reg #(.W(IRQ_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wdata(cpu_wdata), .mask_q(mask_q));

  irq_coll_detect u_coll (
    .strobe(col_strobe), .echo(rx_echo), .dbit(tx_dbit),
    .mode_te(mode_te), .tx_en(tx_en), .hit(coll_hit));

  assign ev_all = {coll_hit, ev_pulse};

  irq_status_reg #(.W(IRQ_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(rd_clr), .ev(ev_all),
    .drop_top(~mode_te), .status_q(status_q));

  assign vis       = visible_status(status_q, mode_te);
  assign cpu_rdata = vis;
  assign irq_d     = any_enabled(vis, mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  assert_coll_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[COLL_IDX]) |-> $past(mode_te && tx_en && col_strobe && (rx_echo != tx_dbit)));

  assert_nt_drops_coll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_te |=> !status_q[COLL_IDX]);

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(cpu_rdata & mask_q)));
endmodule

// File: tb/sim_hdlc_irq_regs.sv
`timescale 1ns/1ps
module sim_hdlc_irq_regs;
  logic clk = 0, rst_n = 0;
  logic sel = 0, rd = 0, wr = 0, te = 1, txen = 0, cstb = 0, echo = 0, dbit = 0;
  logic [7:0] wdata = 0;
  logic [6:0] ev = 0;
  logic [7:0] rdata;
  logic irq;

  int vectors = 0, errors = 0;
  string tag = "R8";
  logic [7:0] m_st = 0, m_mk = 0;
  logic m_irq = 0;

  always #2 clk = ~clk;

  hdlc_irq_regs u0 (
    .clk(clk), .rst_n(rst_n), .cpu_sel(sel), .cpu_rd(rd), .cpu_wr(wr),
    .cpu_wdata(wdata), .cpu_rdata(rdata), .ev_pulse(ev), .mode_te(te),
    .tx_en(txen), .col_strobe(cstb), .rx_echo(echo), .tx_dbit(dbit), .irq(irq));

  function automatic logic [7:0] seen(input logic [7:0] s, input logic t);
    return t ? s : (s & 8'h7f);
  endfunction

  task automatic compare();
    logic [7:0] exp_r;
    exp_r = seen(m_st, te);
    vectors++;
    if (rdata !== exp_r || irq !== m_irq) begin
      errors++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", tag, rdata, irq, exp_r, m_irq);
    end
  endtask

  // One cycle: check, drive, then advance the model at the edge.
  task automatic step(input logic s, input logic r, input logic w, input logic [7:0] wd,
                      input logic [6:0] e, input logic t, input logic tx,
                      input logic cs, input logic ec, input logic db);
    logic [7:0] evv;
    logic nirq;
    @(negedge clk);
    compare();
    sel = s; rd = r; wr = w; wdata = wd; ev = e; te = t; txen = tx;
    cstb = cs; echo = ec; dbit = db;
    @(posedge clk);
    nirq = |(seen(m_st, te) & m_mk);
    evv = {cs & t & tx & (ec != db), e};
    if (s && r) m_st = 8'h00;
    m_st = m_st | evv;
    if (!t) m_st[7] = 1'b0;
    if (s && w) m_mk = wd;
    m_irq = nirq;
  endtask

  task automatic idle(input int n, input logic t);
    for (int i = 0; i < n; i++) step(0,0,0,8'h00,7'h00,t,0,0,0,0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tag = "R8"; idle(3, 1);
    tag = "R1";
    for (int b = 0; b < 7; b++) step(0,0,0,8'h00,7'(1 << b),1,0,0,0,0);
    idle(3, 1);
    tag = "R2";
    step(1,0,1,8'h40,7'h00,1,0,0,0,0);
    idle(3, 1);
    step(1,0,1,8'h00,7'h00,1,0,0,0,0);
    idle(2, 1);
    tag = "R3";
    step(1,1,0,8'h00,7'h00,1,0,0,0,0);
    step(0,1,0,8'h00,7'h05,1,0,0,0,0);
    idle(2, 1);
    step(1,1,0,8'h00,7'h00,1,0,0,0,0);
    idle(2, 1);
    tag = "R4";
    step(1,0,1,8'h08,7'h00,1,0,0,0,0);
    step(0,0,0,8'h00,7'h09,1,0,0,0,0);
    step(1,1,0,8'h00,7'h08,1,0,0,0,0);
    idle(3, 1);
    step(1,1,0,8'h00,7'h00,1,0,0,0,0);
    idle(2, 1);
    tag = "R5";
    step(1,0,1,8'h80,7'h00,1,1,0,0,0);
    step(0,0,0,8'h00,7'h00,1,1,1,1,1);
    step(0,0,0,8'h00,7'h00,1,0,1,1,0);
    step(0,0,0,8'h00,7'h00,1,1,0,1,0);
    idle(2, 1);
    step(0,0,0,8'h00,7'h00,1,1,1,0,1);
    idle(3, 1);
    tag = "R6";
    step(0,0,0,8'h00,7'h00,0,1,0,0,0);
    idle(3, 0);
    step(0,0,0,8'h00,7'h00,0,1,1,1,0);
    idle(2, 0);
    idle(2, 1);
    step(1,1,0,8'h00,7'h00,1,0,0,0,0);
    tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2] & r[3], r[4] & r[5] & r[6],
           8'($urandom), 7'($urandom) & 7'($urandom) & 7'($urandom),
           r[7] | r[8], r[9], r[10], r[11], r[12]);
    end
    idle(2, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule